// File: doc/BRIEF.md
# Host-Port DMA Byte Sequencer

This block carries 24-bit words from a DSP core out to a host over a byte-wide port, with an external DMA controller pacing the transfer. The DSP writes a word into a holding register. As soon as the three-byte receive group is free, the word moves into it, the holding register reads as empty again, and a host request goes up. For each acknowledge pulse the DMA controller receives one byte. An internal byte-address counter chooses which byte goes on the bus.

The word size is set by two mode bits, which give the counter's starting byte. A 24-bit word starts at the high byte, a 16-bit word at the middle byte and an 8-bit word at the low byte. The counter steps up after each byte until the low byte has gone out. Completing the low byte empties the group. If a new word is already waiting, that same completion reloads the group and presets the counter.

Outside DMA mode the host can read the three receive bytes through a register-select port. Inside DMA mode those reads are blocked.

Top module: `hp_dma_seq`

## Requirements
- R1: A holding-register write with the receive group empty fills the group at the second rising edge after the write cycle. At that edge `dsp_tx_ready` returns to 1 and `host_req` rises if `cfg_rx_en` is 1. `dsp_tx_ready` reads 0 from the edge after the write until the word moves out.
- R2: The counter's start byte comes from `cfg_wsize`. Code 01 starts at address 5 (high byte, word bits 23:16), code 10 at address 6 (middle byte, bits 15:8) and code 11 at address 7 (low byte, bits 7:0). As a result, 3, 2 or 1 bytes are delivered per word.
- R3: In DMA mode an acknowledge completes when `host_ack_n` returns high after being low. If the byte just completed was not at address 7, the counter advances by one and `host_req` is high again on the next cycle.
- R4: `host_req` is 0 in every cycle in which `host_ack_n` is 0.
- R5: Completing the address-7 byte empties the group. If no word is waiting, `host_req` stays 0 afterwards.
- R6: If a word is waiting when the address-7 byte completes, it moves in at that same edge and the counter is preset from `cfg_wsize`. `host_req` stays up, `dsp_tx_ready` returns to 1, and the next byte delivered is that word's start byte.
- R7: While `host_ack_n` is 0 in DMA mode, `host_data_oe` is 1 and `host_data` carries the byte the counter selects. In all other cycles `host_data_oe` is 0.
- R8: While DMA mode is on, a `host_rd` of addresses 5 to 7 returns 0 and changes no flag. With DMA mode off, such a read returns the selected byte, and a read of address 7 empties the group.
- R9: A cycle with `cfg_init` high empties the group, sets `dsp_tx_ready` to 1 and ignores a write in that cycle.
- R10: An acknowledge completed while the group is empty is ignored. `host_req` stays 0 and the counter is not moved.
- R11: After reset `host_req` is 0, `dsp_tx_ready` is 1 and `host_data_oe` is 0.
- R12: DMA mode is on only when `cfg_rx_en` is 1 and `cfg_wsize` is not 00. With `cfg_rx_en` at 0, `host_req` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wsize | input | 2 | Word-size mode bits; 00 disables DMA |
| cfg_rx_en | input | 1 | Receive-request enable |
| cfg_init | input | 1 | Initialize command (one cycle) |
| dsp_wr_en | input | 1 | DSP write strobe for the holding register |
| dsp_wr_data | input | 24 | DSP word to send |
| dsp_tx_ready | output | 1 | Holding register empty |
| host_ack_n | input | 1 | DMA acknowledge, active low |
| host_req | output | 1 | Host request, active high |
| host_data | output | 8 | Byte driven to the host during acknowledge |
| host_data_oe | output | 1 | Output enable for `host_data` |
| host_rd | input | 1 | Host register-select read strobe |
| host_addr | input | 3 | Host register-select address |
| host_rd_data | output | 8 | Read data for the register-select port |

## Verification
The hardest case to reach is a low-byte completion that coincides with a waiting word. To get there, the holding register has to be refilled while the previous word is still being drained. The bench therefore writes a second word right after the first has moved, drains the first by acknowledges, and then checks three things: the request never drops, the transmit-ready flag comes back, and the next byte is the new word's start byte. An acknowledge on an empty group is checked the same way: the next word must still begin at its start byte.

// File: rtl/hp_dma_pkg.sv
package hp_dma_pkg;
  typedef struct packed {
    logic rx_full;
    logic tx_empty;
  } hp_flags_t;
endpackage

// File: rtl/hp_ack_edge.sv
module hp_ack_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_n,
  output logic ack_done
);
  logic ack_q;
  logic ack_q_nxt;

  always_comb ack_q_nxt = ack_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b1;
    else        ack_q <= ack_q_nxt;
  end

  // completion = acknowledge released after being low
  assign ack_done = ack_n & ~ack_q;
endmodule

// File: rtl/hp_addr_ctr.sv
module hp_addr_ctr #(
  parameter int ADDR_W     = 3,
  parameter int MODE_W     = 2,
  parameter int FIRST_ADDR = 5,
  parameter int LOW_ADDR   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [MODE_W-1:0] mode,
  output logic [ADDR_W-1:0] cnt,
  output logic              at_low
);
  logic [ADDR_W-1:0] start;
  logic [ADDR_W-1:0] cnt_nxt;

  always_comb begin
    start   = ADDR_W'(FIRST_ADDR - 1) + ADDR_W'(mode);
    cnt_nxt = cnt;
    if (load)      cnt_nxt = start;
    else if (step) cnt_nxt = cnt + ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= ADDR_W'(LOW_ADDR);
    else        cnt <= cnt_nxt;
  end

  assign at_low = (cnt == ADDR_W'(LOW_ADDR));
endmodule

// File: rtl/hp_word_store.sv
module hp_word_store
  import hp_dma_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              pop,
  output hp_flags_t         flags,
  output logic              xfer,
  output logic [WORD_W-1:0] rx_word
);
  logic [WORD_W-1:0] hold, hold_nxt, rx_nxt;
  hp_flags_t         flags_nxt;

  always_comb begin
    xfer      = ~init & ~flags.tx_empty & (~flags.rx_full | pop);
    hold_nxt  = (wr_en & ~init) ? wr_data : hold;
    rx_nxt    = xfer ? hold : rx_word;
    flags_nxt = flags;
    if (init) begin
      flags_nxt.rx_full  = 1'b0;
      flags_nxt.tx_empty = 1'b1;
    end else begin
      if (xfer)     flags_nxt.rx_full = 1'b1;
      else if (pop) flags_nxt.rx_full = 1'b0;
      if (wr_en)     flags_nxt.tx_empty = 1'b0;
      else if (xfer) flags_nxt.tx_empty = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold    <= '0;
      rx_word <= '0;
      flags   <= '{rx_full: 1'b0, tx_empty: 1'b1};
    end else begin
      hold    <= hold_nxt;
      rx_word <= rx_nxt;
      flags   <= flags_nxt;
    end
  end
endmodule

// File: rtl/hp_dma_seq.sv
module hp_dma_seq
  import hp_dma_pkg::*;
#(
  parameter int BYTES    = 3,
  parameter int BYTE_W   = 8,
  parameter int ADDR_W   = 3,
  parameter int LOW_ADDR = 7,
  localparam int WORD_W     = BYTES * BYTE_W,
  localparam int FIRST_ADDR = LOW_ADDR - BYTES + 1,
  localparam int MODE_W     = $clog2(BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] cfg_wsize,
  input  logic              cfg_rx_en,
  input  logic              cfg_init,
  input  logic              dsp_wr_en,
  input  logic [WORD_W-1:0] dsp_wr_data,
  output logic              dsp_tx_ready,
  input  logic              host_ack_n,
  output logic              host_req,
  output logic [BYTE_W-1:0] host_data,
  output logic              host_data_oe,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  output logic [BYTE_W-1:0] host_rd_data
);
  hp_flags_t         flags;
  logic              xfer, pop, ack_done, at_low;
  logic              dma_on, ack_step, ack_pop, host_pop;
  logic [ADDR_W-1:0] cnt;
  logic [WORD_W-1:0] rx_word;

  function automatic logic [BYTE_W-1:0] pick(input logic [WORD_W-1:0] w,
                                             input logic [ADDR_W-1:0] a);
    logic [BYTE_W-1:0] r;
    r = '0;
    for (int i = 0; i < BYTES; i++)
      if (a == ADDR_W'(FIRST_ADDR + i)) r = w[(BYTES-1-i)*BYTE_W +: BYTE_W];
    return r;
  endfunction

  hp_ack_edge u_edge (
    .clk(clk), .rst_n(rst_n), .ack_n(host_ack_n), .ack_done(ack_done)
  );

  always_comb begin
    dma_on   = cfg_rx_en & (cfg_wsize != '0);
    ack_step = dma_on & ack_done & flags.rx_full & ~at_low;
    ack_pop  = dma_on & ack_done & flags.rx_full & at_low;
    host_pop = host_rd & ~dma_on & flags.rx_full &
               (host_addr == ADDR_W'(LOW_ADDR));
    pop      = ack_pop | host_pop;
  end

  hp_word_store #(.WORD_W(WORD_W)) u_store (
    .clk(clk), .rst_n(rst_n), .init(cfg_init),
    .wr_en(dsp_wr_en), .wr_data(dsp_wr_data), .pop(pop),
    .flags(flags), .xfer(xfer), .rx_word(rx_word)
  );

  hp_addr_ctr #(
    .ADDR_W(ADDR_W), .MODE_W(MODE_W),
    .FIRST_ADDR(FIRST_ADDR), .LOW_ADDR(LOW_ADDR)
  ) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(xfer | cfg_init), .step(ack_step),
    .mode(cfg_wsize), .cnt(cnt), .at_low(at_low)
  );

  always_comb begin
    dsp_tx_ready = flags.tx_empty;
    host_req     = flags.rx_full & cfg_rx_en & host_ack_n;
    host_data_oe = dma_on & ~host_ack_n;
    host_data    = host_data_oe ? pick(rx_word, cnt) : '0;
    host_rd_data = (host_rd & ~dma_on) ? pick(rx_word, host_addr) : '0;
  end
endmodule

// File: rtl/hp_dma_seq_chk.sv
module hp_dma_seq_chk #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_ack_n,
  input logic              host_req,
  input logic              host_data_oe,
  input logic              dma_on,
  input logic              ack_done,
  input logic              at_low,
  input logic              xfer,
  input logic              cfg_init,
  input logic              rx_full,
  input logic              tx_empty,
  input logic [ADDR_W-1:0] cnt
);
  // R4
  req_quiet_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_ack_n |-> !host_req);

  // R3
  cnt_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_on && ack_done && rx_full && !at_low && !xfer && !cfg_init)
    |=> cnt == $past(cnt) + ADDR_W'(1));

  // R1
  no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_full && !tx_empty && !cfg_init) |=> (rx_full && tx_empty) || $past(xfer) == 1'b0);

  // R6
  xfer_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> rx_full);

  // R7
  oe_only_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_data_oe |-> (dma_on && !host_ack_n));

  // R9
  init_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_init |=> (!rx_full && tx_empty));
endmodule

bind hp_dma_seq hp_dma_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_ack_n(host_ack_n), .host_req(host_req),
  .host_data_oe(host_data_oe), .dma_on(dma_on), .ack_done(ack_done),
  .at_low(at_low), .xfer(xfer), .cfg_init(cfg_init),
  .rx_full(flags.rx_full), .tx_empty(flags.tx_empty), .cnt(cnt)
);

// File: tb/sim_hp_dma_seq.sv
module sim_hp_dma_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_wsize = 2'b01;
  logic        cfg_rx_en = 1'b1;
  logic        cfg_init = 1'b0;
  logic        dsp_wr_en = 1'b0;
  logic [23:0] dsp_wr_data = '0;
  logic        dsp_tx_ready;
  logic        host_ack_n = 1'b1;
  logic        host_req;
  logic [7:0]  host_data;
  logic        host_data_oe;
  logic        host_rd = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [7:0]  host_rd_data;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  hp_dma_seq u0 (.*);

  // {mode, word}
  localparam logic [25:0] VEC [4] = '{
    {2'b01, 24'hA1B2C3}, {2'b10, 24'h5D6E7F},
    {2'b11, 24'h00FF42}, {2'b01, 24'h8001FE}};

  function automatic logic [7:0] bsel(input logic [23:0] w, input int idx);
    return w[(2-idx)*8 +: 8];
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic write_word(input logic [23:0] w);
    @(negedge clk); dsp_wr_en = 1'b1; dsp_wr_data = w;
    @(negedge clk); dsp_wr_en = 1'b0;
    @(negedge clk);
  endtask

  // one acknowledge; returns byte, oe and request seen while ack low
  task automatic ack_byte(output logic [7:0] d, output logic oe, output logic rq);
    @(negedge clk); host_ack_n = 1'b0;
    @(negedge clk); d = host_data; oe = host_data_oe; rq = host_req;
    host_ack_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic hread(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); host_rd = 1'b1; host_addr = a;
    #1 d = host_rd_data;
    @(negedge clk); host_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic oe, rq;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(host_req == 0, "R11 req", host_req, 0);
    chk(dsp_tx_ready == 1, "R11 tx_ready", dsp_tx_ready, 1);
    chk(host_data_oe == 0, "R11 oe", host_data_oe, 0);

    // table walk: R1 R2 R3 R4 R5 R7
    for (int i = 0; i < 4; i++) begin
      logic [1:0]  m;
      logic [23:0] w;
      int nb;
      m = VEC[i][25:24]; w = VEC[i][23:0]; nb = 4 - int'(m);
      cfg_wsize = m;
      write_word(w);
      chk(host_req == 1, "R1 req after load", host_req, 1);
      chk(dsp_tx_ready == 1, "R1 tx_ready back", dsp_tx_ready, 1);
      for (int b = 0; b < nb; b++) begin
        ack_byte(d, oe, rq);
        chk(d == bsel(w, int'(m) - 1 + b), "R2 R7 byte", d, bsel(w, int'(m) - 1 + b));
        chk(oe == 1, "R7 oe in ack", oe, 1);
        chk(rq == 0, "R4 req low in ack", rq, 0);
        if (b < nb - 1) chk(host_req == 1, "R3 req again", host_req, 1);
        else            chk(host_req == 0, "R5 drained", host_req, 0);
      end
    end

    // R1 R6: second word waits while first drains
    cfg_wsize = 2'b01;
    write_word(24'h112233);
    @(negedge clk); dsp_wr_en = 1'b1; dsp_wr_data = 24'h445566;
    @(negedge clk); dsp_wr_en = 1'b0;
    chk(dsp_tx_ready == 0, "R1 holding busy", dsp_tx_ready, 0);
    ack_byte(d, oe, rq); ack_byte(d, oe, rq); ack_byte(d, oe, rq);
    chk(d == 8'h33, "R6 low of first", d, 8'h33);
    chk(host_req == 1, "R6 req stays", host_req, 1);
    chk(dsp_tx_ready == 1, "R6 tx_ready back", dsp_tx_ready, 1);
    ack_byte(d, oe, rq);
    chk(d == 8'h44, "R6 reload start byte", d, 8'h44);
    ack_byte(d, oe, rq); ack_byte(d, oe, rq);
    chk(host_req == 0, "R5 empty", host_req, 0);

    // R10: acknowledge on empty group ignored
    ack_byte(d, oe, rq);
    chk(host_req == 0, "R10 req stays low", host_req, 0);
    write_word(24'h778899);
    ack_byte(d, oe, rq);
    chk(d == 8'h77, "R10 counter untouched", d, 8'h77);
    // R8: blocked reads in DMA mode
    hread(3'd5, d);
    chk(d == 8'h00, "R8 blocked read", d, 0);
    hread(3'd7, d);
    chk(d == 8'h00, "R8 blocked low read", d, 0);
    chk(host_req == 1, "R8 no flag change", host_req, 1);
    // R12 R8: DMA off, reads allowed
    cfg_wsize = 2'b00;
    ack_byte(d, oe, rq);
    chk(oe == 0, "R12 no drive with mode 00", oe, 0);
    chk(host_req == 1, "R12 ack ignored", host_req, 1);
    hread(3'd6, d);
    chk(d == 8'h88, "R8 mid read", d, 8'h88);
    hread(3'd7, d);
    chk(d == 8'h99, "R8 low read", d, 8'h99);
    chk(host_req == 0, "R8 low read empties", host_req, 0);

    // R9 init
    cfg_wsize = 2'b10;
    write_word(24'hCAFE01);
    chk(host_req == 1, "R9 pre", host_req, 1);
    @(negedge clk); cfg_init = 1'b1;
    @(negedge clk); cfg_init = 1'b0;
    chk(host_req == 0, "R9 group empty", host_req, 0);
    chk(dsp_tx_ready == 1, "R9 tx_ready", dsp_tx_ready, 1);

    // R12: receive enable off
    cfg_rx_en = 1'b0; cfg_wsize = 2'b01;
    write_word(24'h0A0B0C);
    chk(host_req == 0, "R12 no req", host_req, 0);
    ack_byte(d, oe, rq);
    chk(oe == 0, "R12 no drive", oe, 0);

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule